// File: doc/BRIEF.md
# Boundary-Scan Test Access Port for a Memory Device

This block is the serial test port of a memory device. It has no dedicated test reset pin. A 16-state controller, stepped by TMS on the rising edge of TCK, sends serial data from TDI through one of three registers: a 3-bit instruction register, a 1-bit bypass cell, or a 32-bit identification register that loads a constant. In the boundary-scan instructions it uses a boundary register instead.

The boundary register has a parameterised length. Its low cells sample the device pins. The cells above them hold no pin and capture a fixed 1. The instruction that is active after an update controls two outputs to the device ring: `drive_sel` makes the device outputs drive the latched boundary values, and `force_hiz` forces every device output to high impedance.

The only way to initialise the port is by TMS: five rising TCK edges with TMS high. The power-up reset input does the same job at power-on. All inputs are sampled on the rising edge of TCK. TDO, its enable and all parallel outputs change on the falling edge.

Top module: `scan_tap`

## Requirements
- R1: After power-up reset the controller is in Test-Logic-Reset. The active instruction is IDCODE (001), so `drive_sel` and `force_hiz` are both 0.
- R2: Five consecutive rising TCK edges with TMS high reach Test-Logic-Reset from any state. This also restores IDCODE as the active instruction.
- R3: Capture-IR loads 001 into the instruction shift register. Shifting out from Shift-IR therefore shows 1, 0, 0, least significant bit first.
- R4: A shifted instruction becomes active only in Update-IR. While it is being shifted and in Exit1-IR, the previously active instruction stays in force.
- R5: Opcode 111 and the reserved opcodes 011, 101 and 110 select the 1-bit bypass cell. This cell captures 0 in Capture-DR, so TDO repeats TDI one shift later.
- R6: Under IDCODE, Capture-DR loads the 32-bit constant `ID_CODE`, and bit 0 appears on TDO first.
- R7: Opcodes 000 (EXTEST), 010 (SAMPLE-Z) and 100 (SAMPLE/PRELOAD) select the boundary register. In Capture-DR, cell i below `PIN_CNT` loads `pin_sample[i]` and every higher cell loads 1. Cell 0 shifts out first.
- R8: In Update-DR under a boundary instruction, the low `PIN_CNT` boundary cells are latched onto `bsr_drive`. These values stay on `bsr_drive` when the instruction changes.
- R9: `drive_sel` is 1 only while EXTEST is active. `force_hiz` is 1 only while SAMPLE-Z is active. The two are never 1 together.
- R10: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R11: `drive_sel`, `force_hiz`, `bsr_drive`, `tdo` and `tdo_oe` change only on the falling edge of TCK, never on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| pwr_rst_n | input | 1 | Power-up reset, asynchronous, active low |
| tms | input | 1 | Controller mode select |
| tdi | input | 1 | Serial data in |
| pin_sample | input | PIN_CNT | Pin levels captured into the boundary register |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Drive enable for TDO |
| bsr_drive | output | PIN_CNT | Latched boundary values for the device outputs |
| drive_sel | output | 1 | Device outputs take their values from `bsr_drive` |
| force_hiz | output | 1 | All device outputs forced to high impedance |

## Verification
The bench builds the block with a 20-cell boundary register of which 14 cells face pins, and with an identification constant different from the default. This leaves six placeholder cells whose captured 1s can be told apart from the pin data, and it makes a full-length scan compare every position. Each instruction code, reserved ones included, is loaded through the serial port. Output timing is observed between the rising and falling edges of an Update-IR cycle.

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int          BSR_LEN = 16,
  parameter int          PIN_CNT = 12,
  parameter logic [31:0] ID_CODE = 32'h1A5C_3E49
) (
  input  logic               tck,
  input  logic               pwr_rst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [PIN_CNT-1:0] pin_sample,
  output logic               tdo,
  output logic               tdo_oe,
  output logic [PIN_CNT-1:0] bsr_drive,
  output logic               drive_sel,
  output logic               force_hiz
);

  localparam logic [2:0] OP_EXTEST = 3'b000;
  localparam logic [2:0] OP_IDCODE = 3'b001;
  localparam logic [2:0] OP_HIZ    = 3'b010;
  localparam logic [2:0] OP_SAMPLE = 3'b100;
  localparam logic [2:0] IR_CAP    = 3'b001;

  typedef enum logic [3:0] {
    S_EX2DR = 4'h0, S_EX1DR = 4'h1, S_SHDR  = 4'h2, S_PSDR  = 4'h3,
    S_SELIR = 4'h4, S_UPDR  = 4'h5, S_CAPDR = 4'h6, S_SELDR = 4'h7,
    S_EX2IR = 4'h8, S_EX1IR = 4'h9, S_SHIR  = 4'hA, S_PSIR  = 4'hB,
    S_RTI   = 4'hC, S_UPIR  = 4'hD, S_CAPIR = 4'hE, S_TLR   = 4'hF
  } tap_st_t;

  tap_st_t state_q, state_d;

  always_comb begin
    unique case (state_q)
      S_TLR:   state_d = tms ? S_TLR   : S_RTI;
      S_RTI:   state_d = tms ? S_SELDR : S_RTI;
      S_SELDR: state_d = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: state_d = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  state_d = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: state_d = tms ? S_UPDR  : S_PSDR;
      S_PSDR:  state_d = tms ? S_EX2DR : S_PSDR;
      S_EX2DR: state_d = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  state_d = tms ? S_SELDR : S_RTI;
      S_SELIR: state_d = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: state_d = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  state_d = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: state_d = tms ? S_UPIR  : S_PSIR;
      S_PSIR:  state_d = tms ? S_EX2IR : S_PSIR;
      S_EX2IR: state_d = tms ? S_UPIR  : S_SHIR;
      S_UPIR:  state_d = tms ? S_SELDR : S_RTI;
      default: state_d = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge pwr_rst_n)
    if (!pwr_rst_n) state_q <= S_TLR;
    else            state_q <= state_d;

  logic [2:0]         ir_sh, ir_q;
  logic               byp_q;
  logic [31:0]        id_sh;
  logic [BSR_LEN-1:0] bsr_sh, cap_vec;

  wire sel_bsr = (ir_q == OP_EXTEST) || (ir_q == OP_HIZ) || (ir_q == OP_SAMPLE);
  wire sel_id  = (ir_q == OP_IDCODE);

  always_comb begin
    cap_vec = '1;
    cap_vec[PIN_CNT-1:0] = pin_sample;
  end

  always_ff @(posedge tck or negedge pwr_rst_n)
    if (!pwr_rst_n) ir_sh <= IR_CAP;
    else if (state_q == S_CAPIR) ir_sh <= IR_CAP;
    else if (state_q == S_SHIR)  ir_sh <= {tdi, ir_sh[2:1]};

  always_ff @(posedge tck or negedge pwr_rst_n)
    if (!pwr_rst_n) begin
      byp_q  <= 1'b0;
      id_sh  <= '0;
      bsr_sh <= '0;
    end else if (state_q == S_CAPDR) begin
      if (sel_id)       id_sh  <= ID_CODE;
      else if (sel_bsr) bsr_sh <= cap_vec;
      else              byp_q  <= 1'b0;
    end else if (state_q == S_SHDR) begin
      if (sel_id)       id_sh  <= {tdi, id_sh[31:1]};
      else if (sel_bsr) bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
      else              byp_q  <= tdi;
    end

  always_ff @(negedge tck or negedge pwr_rst_n)
    if (!pwr_rst_n)              ir_q <= OP_IDCODE;
    else if (state_q == S_TLR)   ir_q <= OP_IDCODE;
    else if (state_q == S_UPIR)  ir_q <= ir_sh;

  always_ff @(negedge tck or negedge pwr_rst_n)
    if (!pwr_rst_n) bsr_drive <= '0;
    else if (state_q == S_UPDR && sel_bsr) bsr_drive <= bsr_sh[PIN_CNT-1:0];

  always_ff @(negedge tck or negedge pwr_rst_n)
    if (!pwr_rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state_q == S_SHIR) || (state_q == S_SHDR);
      if (state_q == S_SHIR) tdo <= ir_sh[0];
      else if (sel_id)       tdo <= id_sh[0];
      else if (sel_bsr)      tdo <= bsr_sh[0];
      else                   tdo <= byp_q;
    end

  assign drive_sel = (ir_q == OP_EXTEST);
  assign force_hiz = (ir_q == OP_HIZ);

endmodule

module scan_tap_chk (
  input logic       tck,
  input logic       pwr_rst_n,
  input logic       tms,
  input logic [3:0] st,
  input logic [2:0] ir,
  input logic       tdo_oe,
  input logic       drive_sel,
  input logic       force_hiz
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge pwr_rst_n)
    if (!pwr_rst_n) ones_cnt <= '0;
    else if (!tms)  ones_cnt <= '0;
    else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!pwr_rst_n)
    (ones_cnt >= 3'd5) |-> (st == 4'hF)); // R2

  AST_IR_HELD_OFF_UPDATE: assert property (@(negedge tck) disable iff (!pwr_rst_n)
    (st != 4'hD && st != 4'hF) |=> $stable(ir)); // R4

  AST_HIZ_DRIVE_EXCL: assert property (@(posedge tck) disable iff (!pwr_rst_n)
    !(drive_sel && force_hiz)); // R9

  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!pwr_rst_n)
    tdo_oe |-> (st == 4'h2 || st == 4'hA)); // R10

  AST_DRIVE_FALL_ONLY: assert property (@(negedge tck) disable iff (!pwr_rst_n)
    drive_sel |-> (ir == 3'b000)); // R9
endmodule

bind scan_tap scan_tap_chk chk_i (
  .tck(tck), .pwr_rst_n(pwr_rst_n), .tms(tms), .st(state_q), .ir(ir_q),
  .tdo_oe(tdo_oe), .drive_sel(drive_sel), .force_hiz(force_hiz)
);

// File: tb/scan_tap_tb_top.sv
module scan_tap_tb_top;
  localparam int          TCK_P   = 20;
  localparam int          BLEN    = 20;
  localparam int          PCNT    = 14;
  localparam logic [31:0] IDV     = 32'h5A3C_E1F7;

  logic tck = 1'b0, pwr_rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [PCNT-1:0] pin_sample = '0;
  logic tdo, tdo_oe, drive_sel, force_hiz;
  logic [PCNT-1:0] bsr_drive;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(TCK_P/2) tck = ~tck;

  scan_tap #(.BSR_LEN(BLEN), .PIN_CNT(PCNT), .ID_CODE(IDV)) dut_i (
    .tck(tck), .pwr_rst_n(pwr_rst_n), .tms(tms), .tdi(tdi), .pin_sample(pin_sample),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsr_drive(bsr_drive),
    .drive_sel(drive_sel), .force_hiz(force_hiz));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic tlr_to_rti();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap, output bit oe_ok);
    oe_ok = 1;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      if (!tdo_oe) oe_ok = 0;
      step(i == 2, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout, output bit oe_ok);
    oe_ok = 1; dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      if (!tdo_oe) oe_ok = 0;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset_idcode();
    logic [63:0] q; bit ok;
    check(drive_sel == 0 && force_hiz == 0, "R1 reset outputs", {drive_sel, force_hiz}, 0);
    check(tdo_oe == 0, "R10 oe idle after reset", tdo_oe, 0);
    step(0, 0);
    scan_dr(64'h0, 32, q, ok);
    check(q[31:0] == IDV, "R1/R6 default IDCODE scan", q[31:0], IDV);
    check(ok, "R10 oe high in Shift-DR", ok, 1);
    check(tdo_oe == 0, "R10 oe low in Run-Test-Idle", tdo_oe, 0);
  endtask

  task automatic t_ir_capture();
    logic [2:0] c; bit ok;
    load_ir(3'b001, c, ok);
    check(c == 3'b001, "R3 Capture-IR pattern", c, 3'b001);
    check(ok, "R10 oe high in Shift-IR", ok, 1);
  endtask

  task automatic t_bypass();
    logic [2:0] c; logic [63:0] q; bit ok;
    logic [2:0] codes [4] = '{3'b111, 3'b011, 3'b101, 3'b110};
    for (int k = 0; k < 4; k++) begin
      load_ir(codes[k], c, ok);
      scan_dr(64'hB5, 8, q, ok);
      check(q[7:0] == 8'h6A, $sformatf("R5 bypass opcode %b", codes[k]), q[7:0], 8'h6A);
    end
  endtask

  task automatic t_bsr_capture();
    logic [2:0] c; logic [63:0] q; bit ok;
    logic [BLEN-1:0] exp;
    pin_sample = 14'h2A5C;
    load_ir(3'b100, c, ok);
    scan_dr(64'h0, BLEN, q, ok);
    exp = {6'h3F, 14'h2A5C};
    check(q[BLEN-1:0] == exp, "R7 boundary capture with placeholders", q[BLEN-1:0], exp);
    check(drive_sel == 0 && force_hiz == 0, "R9 preload drives nothing", {drive_sel, force_hiz}, 0);
  endtask

  task automatic t_preload_extest();
    logic [2:0] c; logic [63:0] q; bit ok;
    logic [BLEN-1:0] d = 20'hC3_1E7;
    scan_dr({44'h0, d}, BLEN, q, ok);
    check(bsr_drive == d[PCNT-1:0], "R8 preload latched on Update-DR", bsr_drive, d[PCNT-1:0]);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) step(i == 2, 1'b0);
    check(drive_sel == 0, "R4 not active in Exit1-IR", drive_sel, 0);
    tms = 1;
    @(posedge tck); #1;
    check(drive_sel == 0, "R11 no change at rising edge", drive_sel, 0);
    @(negedge tck); #1;
    check(drive_sel == 1 && force_hiz == 0, "R4/R9 EXTEST active after Update-IR", {drive_sel, force_hiz}, 2'b10);
    step(0, 0);
    check(bsr_drive == d[PCNT-1:0], "R8 values held across instruction change", bsr_drive, d[PCNT-1:0]);
  endtask

  task automatic t_samplez();
    logic [2:0] c; logic [63:0] q; bit ok;
    load_ir(3'b010, c, ok);
    check(force_hiz == 1 && drive_sel == 0, "R9 SAMPLE-Z outputs", {drive_sel, force_hiz}, 2'b01);
    pin_sample = 14'h1B03;
    scan_dr(64'h0, BLEN, q, ok);
    check(q[BLEN-1:0] == {6'h3F, 14'h1B03}, "R7/R9 SAMPLE-Z selects boundary", q[BLEN-1:0], {6'h3F, 14'h1B03});
  endtask

  task automatic t_tlr_five();
    logic [2:0] c; logic [63:0] q; bit ok;
    load_ir(3'b111, c, ok);
    step(1, 0); step(0, 0); step(0, 0);
    check(tdo_oe == 1, "R10 oe in Shift-DR", tdo_oe, 1);
    for (int i = 0; i < 5; i++) step(1, 0);
    check(tdo_oe == 0 && drive_sel == 0 && force_hiz == 0, "R2 state after five TMS highs", {tdo_oe, drive_sel, force_hiz}, 0);
    step(0, 0);
    scan_dr(64'h0, 32, q, ok);
    check(q[31:0] == IDV, "R2 IDCODE restored", q[31:0], IDV);
  endtask

  initial begin
    #(TCK_P * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(TCK_P * 2 + 3);
    pwr_rst_n = 1'b1;
    @(negedge tck); #1;
    t_reset_idcode();
    t_ir_capture();
    t_bypass();
    t_bsr_capture();
    t_preload_extest();
    t_samplez();
    t_tlr_five();
    tlr_to_rti();
    check(tdo_oe == 0, "R10 oe idle at end", tdo_oe, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule